// File: doc/BRIEF.md
# Asynchronous SRAM Access Controller

This block sits between a synchronous system bus and an external asynchronous static RAM of 32768 bytes. The host side uses a simple request/ready handshake. A request carries a 15-bit word address, a direction bit and 8 bits of write data. The controller turns each request into a sequence of strobes on the memory pins, timed in whole clock cycles. It drives the address, an active-low chip select, an active-low write enable and an active-low output enable. The memory data bus is split into an output byte, an input byte and a drive enable, so that a pad ring can build the tri-state pin.

Each interval is given in nanoseconds as a parameter. Elaboration rounds it up to whole clock periods. A write is framed as the window in which chip select and write enable are both low. Write enable rises first, which ends the write while address and data are still driven. A read keeps write enable high the whole time. It releases the bus before output enable falls, and it waits out the memory's output float time before the next access.

The state machine has seven states. IDLE is the deselected, low-power state. A request in IDLE with the direction bit set goes to WR_SETUP. A request with the direction bit clear goes to RD_TURN. The write path runs WR_SETUP, then WR_PULSE, then WR_HOLD, then IDLE, each step taken when the phase timer expires. The read path runs RD_TURN, then RD_ACCESS, then RD_FLOAT, then IDLE. Read data is captured on the step from RD_ACCESS to RD_FLOAT. Both steps back into IDLE raise ready for one clock.

Top module: `asram_ctrl`

## Requirements
- R1: After reset and whenever idle, mem_cs_n, mem_we_n and mem_oe_n are 1, mem_dq_oe is 0 and ready is 0.
- R2: A write first drives address and data for one cycle with all strobes high. It then holds mem_cs_n and mem_we_n low together for exactly PULSE_CYC cycles. PULSE_CYC is the largest of ceil(T_WP_NS/T_CLK_NS), ceil(T_AW_NS/T_CLK_NS) and ceil(T_DS_NS/T_CLK_NS), which is 8 by default.
- R3: A write ends with mem_we_n rising while mem_cs_n stays low for one more cycle. Address and data remain driven and unchanged in that cycle. ready rises 1+PULSE_CYC+HOLD_CYC cycles after the accepting edge, which is 10 by default.
- R4: A read spends TURN_CYC cycles with the bus released and all strobes high. It then holds mem_cs_n and mem_oe_n low for exactly ACC_CYC = ceil(T_ACC_NS/T_CLK_NS) cycles, which is 10 by default. mem_we_n stays 1 throughout.
- R5: rdata takes mem_dq_in on the last edge of the output-enable window and holds that value until the next read. ready rises FLOAT_CYC = ceil(T_FLOAT_NS/T_CLK_NS) cycles later, which is 4 by default. The read latency from the accepting edge is 15 by default.
- R6: mem_dq_oe is 1 only during write phases. It is never 1 while mem_oe_n is 0. At least one cycle separates mem_dq_oe falling and mem_oe_n falling.
- R7: ready is a single-cycle pulse, one per accepted request.
- R8: A request raised while an access is in progress is ignored. It changes neither the memory contents nor the sequence in progress.
- R9: mem_addr does not change while mem_cs_n is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req | input | 1 | Access request, accepted only in IDLE |
| req_we | input | 1 | 1 = write, 0 = read |
| req_addr | input | 15 | Word address |
| req_wdata | input | 8 | Write data |
| ready | output | 1 | One-cycle completion pulse |
| rdata | output | 8 | Last captured read data |
| mem_addr | output | 15 | Memory address pins |
| mem_cs_n | output | 1 | Chip select, active low |
| mem_we_n | output | 1 | Write enable, active low |
| mem_oe_n | output | 1 | Output enable, active low |
| mem_dq_out | output | 8 | Data driven toward the memory |
| mem_dq_oe | output | 1 | Drive enable for the data pins |
| mem_dq_in | input | 8 | Data received from the memory |

## Verification
A stuck or skipped state shows at the pins within one access. The write or output-enable window comes out longer or shorter than its count, or ready arrives at the wrong latency, so a mistimed phase is caught on the first transaction that uses it. A wrong timer reload or a wrong capture edge shows up as corrupted read-back data. The bench memory model returns inverted data whenever the read strobes are not active, so a capture on the wrong edge reads back the wrong byte. A bus-ownership error shows the same cycle it happens, as the drive enable and output enable overlapping.

// File: rtl/asram_pkg.sv
package asram_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_WR_SETUP,
        ST_WR_PULSE,
        ST_WR_HOLD,
        ST_RD_TURN,
        ST_RD_ACCESS,
        ST_RD_FLOAT
    } asram_state_e;

    function automatic int ceil_cyc(input int ns, input int clk_ns);
        return (ns + clk_ns - 1) / clk_ns;
    endfunction

    function automatic int imax(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/asram_phase_timer.sv
module asram_phase_timer #(
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             expired
);
    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign expired = (cnt_q == '0);

    // R2
    timer_no_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - 1'b1));
endmodule

// File: rtl/asram_datapath.sv
module asram_datapath #(
    parameter int ADDR_W = 15,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              accept,
    input  logic              capture,
    input  logic [ADDR_W-1:0] in_addr,
    input  logic [DATA_W-1:0] in_wdata,
    input  logic [DATA_W-1:0] pin_din,
    output logic [ADDR_W-1:0] pin_addr,
    output logic [DATA_W-1:0] pin_dout,
    output logic [DATA_W-1:0] rd_byte
);
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pin_addr <= '0;
            pin_dout <= '0;
            rd_byte  <= '0;
        end else begin
            if (accept) begin
                pin_addr <= in_addr;
                pin_dout <= in_wdata;
            end
            if (capture) begin
                rd_byte <= pin_din;
            end
        end
    end

    // R8
    dp_latch_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!accept) |=> $stable(pin_addr) && $stable(pin_dout));
endmodule

// File: rtl/asram_ctrl.sv
module asram_ctrl
    import asram_pkg::*;
#(
    parameter int ADDR_W     = 15,
    parameter int DATA_W     = 8,
    parameter int T_CLK_NS   = 4,
    parameter int T_CYCLE_NS = 40,
    parameter int T_WP_NS    = 30,
    parameter int T_AW_NS    = 30,
    parameter int T_DS_NS    = 22,
    parameter int T_ACC_NS   = 40,
    parameter int T_FLOAT_NS = 15,
    parameter int T_TURN_NS  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req,
    input  logic              req_we,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              ready,
    output logic [DATA_W-1:0] rdata,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_cs_n,
    output logic              mem_we_n,
    output logic              mem_oe_n,
    output logic [DATA_W-1:0] mem_dq_out,
    output logic              mem_dq_oe,
    input  logic [DATA_W-1:0] mem_dq_in
);
    localparam int SETUP_CYC = 1;
    localparam int PULSE_CYC = imax(imax(ceil_cyc(T_WP_NS, T_CLK_NS),
                                         ceil_cyc(T_AW_NS, T_CLK_NS)),
                                    imax(ceil_cyc(T_DS_NS, T_CLK_NS), 1));
    localparam int HOLD_CYC  = imax(1, ceil_cyc(T_CYCLE_NS, T_CLK_NS) - SETUP_CYC - PULSE_CYC);
    localparam int TURN_CYC  = imax(1, ceil_cyc(T_TURN_NS, T_CLK_NS));
    localparam int ACC_CYC   = imax(1, ceil_cyc(T_ACC_NS, T_CLK_NS));
    localparam int FLOAT_CYC = imax(1, ceil_cyc(T_FLOAT_NS, T_CLK_NS));
    localparam int MAX_CYC   = imax(imax(PULSE_CYC, HOLD_CYC),
                                    imax(imax(TURN_CYC, ACC_CYC), FLOAT_CYC));
    localparam int CNT_W     = $clog2(MAX_CYC + 1);

    asram_state_e     state_q, state_nxt;
    logic             tmr_load;
    logic [CNT_W-1:0] tmr_val;
    logic             tmr_done;
    logic             accept;
    logic             capture;
    logic             finish;

    asram_phase_timer #(.CNT_W(CNT_W)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (tmr_val),
        .expired  (tmr_done)
    );

    asram_datapath #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dp (
        .clk      (clk),
        .rst_n    (rst_n),
        .accept   (accept),
        .capture  (capture),
        .in_addr  (req_addr),
        .in_wdata (req_wdata),
        .pin_din  (mem_dq_in),
        .pin_addr (mem_addr),
        .pin_dout (mem_dq_out),
        .rd_byte  (rdata)
    );

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_nxt;
        end
    end

    // Next state and phase timer reloads
    always_comb begin
        state_nxt = state_q;
        tmr_load  = 1'b0;
        tmr_val   = '0;
        accept    = 1'b0;
        capture   = 1'b0;
        finish    = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (req) begin
                    accept   = 1'b1;
                    tmr_load = 1'b1;
                    if (req_we) begin
                        state_nxt = ST_WR_SETUP;
                        tmr_val   = CNT_W'(SETUP_CYC - 1);
                    end else begin
                        state_nxt = ST_RD_TURN;
                        tmr_val   = CNT_W'(TURN_CYC - 1);
                    end
                end
            end
            ST_WR_SETUP: begin
                if (tmr_done) begin
                    state_nxt = ST_WR_PULSE;
                    tmr_load  = 1'b1;
                    tmr_val   = CNT_W'(PULSE_CYC - 1);
                end
            end
            ST_WR_PULSE: begin
                if (tmr_done) begin
                    state_nxt = ST_WR_HOLD;
                    tmr_load  = 1'b1;
                    tmr_val   = CNT_W'(HOLD_CYC - 1);
                end
            end
            ST_WR_HOLD: begin
                if (tmr_done) begin
                    state_nxt = ST_IDLE;
                    finish    = 1'b1;
                end
            end
            ST_RD_TURN: begin
                if (tmr_done) begin
                    state_nxt = ST_RD_ACCESS;
                    tmr_load  = 1'b1;
                    tmr_val   = CNT_W'(ACC_CYC - 1);
                end
            end
            ST_RD_ACCESS: begin
                if (tmr_done) begin
                    state_nxt = ST_RD_FLOAT;
                    capture   = 1'b1;
                    tmr_load  = 1'b1;
                    tmr_val   = CNT_W'(FLOAT_CYC - 1);
                end
            end
            ST_RD_FLOAT: begin
                if (tmr_done) begin
                    state_nxt = ST_IDLE;
                    finish    = 1'b1;
                end
            end
            default: state_nxt = ST_IDLE;
        endcase
    end

    // Registered strobes, decoded from the state being entered
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mem_cs_n  <= 1'b1;
            mem_we_n  <= 1'b1;
            mem_oe_n  <= 1'b1;
            mem_dq_oe <= 1'b0;
            ready     <= 1'b0;
        end else begin
            mem_cs_n  <= !(state_nxt == ST_WR_PULSE || state_nxt == ST_WR_HOLD ||
                           state_nxt == ST_RD_ACCESS);
            mem_we_n  <= (state_nxt != ST_WR_PULSE);
            mem_oe_n  <= (state_nxt != ST_RD_ACCESS);
            mem_dq_oe <= (state_nxt == ST_WR_SETUP || state_nxt == ST_WR_PULSE ||
                          state_nxt == ST_WR_HOLD);
            ready     <= finish;
        end
    end

    // R6
    bus_overlap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_dq_oe |-> mem_oe_n);

    // R6
    bus_turnaround_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(mem_oe_n) |-> !$past(mem_dq_oe));

    // R2
    we_inside_cs_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_we_n |-> (!mem_cs_n && mem_dq_oe && mem_oe_n));

    // R3
    write_end_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_we_n) |-> (!mem_cs_n && mem_dq_oe && $stable(mem_dq_out)));

    // R7
    ready_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ready |=> !ready);

    // R9
    addr_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!mem_cs_n && !$past(mem_cs_n)) |-> $stable(mem_addr));

    // R4
    read_we_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_oe_n |-> mem_we_n);
endmodule

// File: tb/asram_ctrl_tb.sv
module asram_ctrl_tb_top;
    localparam int CLK_NS = 4;
    localparam int AW = 15;
    localparam int DW = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req = 1'b0;
    logic          req_we = 1'b0;
    logic [AW-1:0] req_addr = '0;
    logic [DW-1:0] req_wdata = '0;
    logic          ready;
    logic [DW-1:0] rdata;
    logic [AW-1:0] mem_addr;
    logic          mem_cs_n, mem_we_n, mem_oe_n, mem_dq_oe;
    logic [DW-1:0] mem_dq_out;
    logic [DW-1:0] mem_dq_in;

    int checks = 0;
    int errors = 0;

    logic [DW-1:0] mem_arr [0:(1<<AW)-1];
    logic [DW-1:0] ref_arr [0:(1<<AW)-1];

    always #(CLK_NS/2) clk = ~clk;

    asram_ctrl dut_i (
        .clk(clk), .rst_n(rst_n), .req(req), .req_we(req_we),
        .req_addr(req_addr), .req_wdata(req_wdata), .ready(ready), .rdata(rdata),
        .mem_addr(mem_addr), .mem_cs_n(mem_cs_n), .mem_we_n(mem_we_n),
        .mem_oe_n(mem_oe_n), .mem_dq_out(mem_dq_out), .mem_dq_oe(mem_dq_oe),
        .mem_dq_in(mem_dq_in)
    );

    function automatic int cdiv(input int ns);
        return (ns + CLK_NS - 1) / CLK_NS;
    endfunction
    function automatic int mx(input int a, input int b);
        return (a > b) ? a : b;
    endfunction
    function automatic int exp_pulse();
        return mx(mx(cdiv(30), cdiv(30)), cdiv(22));
    endfunction
    function automatic int exp_wr_lat();
        return 1 + exp_pulse() + mx(1, cdiv(40) - 1 - exp_pulse());
    endfunction
    function automatic int exp_acc();
        return cdiv(40);
    endfunction
    function automatic int exp_rd_lat();
        return mx(1, cdiv(4)) + exp_acc() + cdiv(15);
    endfunction
    function automatic logic [DW-1:0] init_val(input int a);
        return DW'(a) ^ DW'(a >> 8) ^ 8'h3C;
    endfunction

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    // Memory model: data valid only while the read strobes are active
    assign mem_dq_in = (!mem_cs_n && !mem_oe_n && mem_we_n) ? mem_arr[mem_addr]
                                                            : ~mem_arr[mem_addr];

    logic          p_cs_n = 1'b1, p_we_n = 1'b1, p_oe_n = 1'b1, p_dq_oe = 1'b0;
    logic [AW-1:0] p_addr = '0;
    logic [DW-1:0] p_dout = '0;
    int pw = 0;
    int ow = 0;
    int rel = 99;
    int writes_seen = 0;

    always @(negedge clk) begin
        if (rst_n) begin
            if (mem_dq_oe) check(mem_oe_n, "R6 drive with oe low", mem_oe_n, 1);
            if (!mem_oe_n && p_oe_n) check(rel >= 1, "R6 turnaround", rel, 1);
            if (!mem_oe_n) check(mem_we_n, "R4 we during read", mem_we_n, 1);
            if (!mem_cs_n && !p_cs_n) check(mem_addr == p_addr, "R9 addr stable", mem_addr, p_addr);
            if (!mem_cs_n && !mem_we_n) pw++;
            if (!p_cs_n && !p_we_n && !(!mem_cs_n && !mem_we_n)) begin
                check(pw == exp_pulse(), "R2 write pulse width", pw, exp_pulse());
                check(mem_we_n && !mem_cs_n, "R3 we rises first", {mem_cs_n, mem_we_n}, 2'b01);
                check(mem_dq_oe && mem_dq_out == p_dout && mem_addr == p_addr,
                      "R3 hold after write", mem_dq_out, p_dout);
                mem_arr[p_addr] = p_dout;
                writes_seen++;
                pw = 0;
            end
            if (!mem_oe_n) ow++;
            if (!p_oe_n && mem_oe_n) begin
                check(ow == exp_acc(), "R4 oe window", ow, exp_acc());
                ow = 0;
            end
            rel = mem_dq_oe ? 0 : ((rel < 99) ? rel + 1 : rel);
        end
        p_cs_n = mem_cs_n; p_we_n = mem_we_n; p_oe_n = mem_oe_n;
        p_dq_oe = mem_dq_oe; p_addr = mem_addr; p_dout = mem_dq_out;
    end

    task automatic access(input bit w, input logic [AW-1:0] a, input logic [DW-1:0] d,
                          input bit intrude);
        int n;
        @(negedge clk);
        req = 1'b1; req_we = w; req_addr = a; req_wdata = d;
        @(posedge clk);
        n = 0;
        forever begin
            @(posedge clk);
            n++;
            @(negedge clk);
            if (n == 1) req = 1'b0;
            if (intrude && n == 3) begin
                req = 1'b1; req_we = 1'b1; req_addr = a ^ 15'h0555; req_wdata = ~d;
            end
            if (intrude && n == 4) req = 1'b0;
            if (ready || n > 200) break;
        end
        if (w) begin
            ref_arr[a] = d;
            check(n == exp_wr_lat(), "R3 write latency", n, exp_wr_lat());
        end else begin
            check(n == exp_rd_lat(), "R5 read latency", n, exp_rd_lat());
            check(rdata == ref_arr[a], "R5 read data", rdata, ref_arr[a]);
        end
        @(negedge clk);
        check(!ready, "R7 ready single pulse", ready, 0);
        check(mem_cs_n && mem_we_n && mem_oe_n && !mem_dq_oe, "R1 idle strobes",
              {mem_cs_n, mem_we_n, mem_oe_n, mem_dq_oe}, 4'b1110);
        if (!w) check(rdata == ref_arr[a], "R5 rdata held", rdata, ref_arr[a]);
    endtask

    initial begin
        int wr_count;
        void'($urandom(32'h5EED_1234));
        for (int i = 0; i < (1 << AW); i++) begin
            mem_arr[i] = init_val(i);
            ref_arr[i] = init_val(i);
        end
        repeat (4) @(posedge clk);
        @(negedge clk);
        check(mem_cs_n && mem_we_n && mem_oe_n && !mem_dq_oe && !ready, "R1 reset state",
              {mem_cs_n, mem_we_n, mem_oe_n, mem_dq_oe, ready}, 5'b11100);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        check(mem_cs_n && mem_we_n && mem_oe_n && !mem_dq_oe && !ready, "R1 idle after reset",
              {mem_cs_n, mem_we_n, mem_oe_n, mem_dq_oe, ready}, 5'b11100);

        // Directed corners: address and data extremes
        access(1'b1, 15'h0000, 8'h00, 1'b0);
        access(1'b1, 15'h7FFF, 8'hFF, 1'b0);
        access(1'b0, 15'h0000, 8'h00, 1'b0);
        access(1'b0, 15'h7FFF, 8'h00, 1'b0);
        access(1'b0, 15'h1234, 8'h00, 1'b0);

        // R8: request raised mid-write is dropped
        wr_count = writes_seen;
        access(1'b1, 15'h0123, 8'h5A, 1'b1);
        check(writes_seen == wr_count + 1, "R8 single write strobe", writes_seen, wr_count + 1);
        access(1'b0, 15'h0123 ^ 15'h0555, 8'h00, 1'b0);
        access(1'b0, 15'h0123, 8'h00, 1'b0);

        // R8: request raised mid-read is dropped
        wr_count = writes_seen;
        access(1'b0, 15'h0200, 8'h77, 1'b1);
        check(writes_seen == wr_count, "R8 no write during read", writes_seen, wr_count);
        access(1'b0, 15'h0200 ^ 15'h0555, 8'h00, 1'b0);

        // Back-to-back write then read of the same address (R6 turnaround)
        access(1'b1, 15'h4444, 8'hA7, 1'b0);
        access(1'b0, 15'h4444, 8'h00, 1'b0);

        // Constrained random mix over a small address window
        for (int k = 0; k < 150; k++) begin
            logic [AW-1:0] ra;
            ra = AW'($urandom_range(0, 63)) | ((k % 2 == 1) ? 15'h7FC0 : 15'h0000);
            access(($urandom_range(0, 1) == 1), ra, DW'($urandom), 1'b0);
        end

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #(CLK_NS * 150000);
        errors++;
        checks++;
        $display("FAIL watchdog expired actual=0 expected=1");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule